// File: doc/BRIEF.md
# Per-Channel Gain-Selectable Sample Truncator

This block sits on the sample path between the digitiser and the output formatter. Each valid sample is 10 bits wide and carries the index of its input channel. In zero-suppressed operation the block cuts the sample to 8 bits. Each channel has one bit in a gain mask. When the bit is 0, the channel uses normal gain and the upper eight bits of the sample are kept. When the bit is 1, the channel uses half gain and the middle eight bits are kept. A half-gain sample whose top bit is set cannot fit in that window, so it clips to full scale and does not wrap.

In raw operation the full 10-bit value passes through unchanged and the gain mask has no effect. The output bus is 10 bits wide in every mode. In zero-suppressed mode the 8-bit result sits in the low bits and the top two bits are zero. A flag tells which kind of value the output carries. Output and valid are registered together, one cycle after the input.

The gain mask is loaded through a simple write port and can be read back at any time. A write takes effect from the cycle after it is presented. A sample in the same cycle as a write still uses the old mask.

Top module: `gain_trunc_top`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, `out_raw` is 0, and `gain_mask_rd` is all zeros (every channel at normal gain).
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `out_data` and `out_raw` belong to the sample accepted in that earlier cycle.
- R3: In zero-suppressed mode (`zs_mode`=1), a channel whose mask bit is 0 outputs `out_data` = {2'b00, sample[9:2]}, the sample divided by 4 with rounding down. `out_raw` is 0.
- R4: In zero-suppressed mode, a channel whose mask bit is 1 and whose sample has bit 9 clear outputs {2'b00, sample[8:1]}, the sample divided by 2 with rounding down.
- R5: In zero-suppressed mode, a channel whose mask bit is 1 and whose sample has bit 9 set outputs 10'h0FF (saturated) and does not wrap.
- R6: In raw mode (`zs_mode`=0), `out_data` equals the 10-bit input sample unchanged whatever the mask, and `out_raw` is 1.
- R7: Mask bit i (bit position = channel index) changes only samples of channel i. Samples on other channels are unaffected.
- R8: When `gain_mask_we` is 1, `gain_mask_wdata` is loaded into the mask and appears on `gain_mask_rd` one clock later. When it is 0, the mask holds.
- R9: A sample accepted in the same cycle as a mask write is processed with the mask value from before the write.
- R10: While `in_valid` is 0, `out_data` and `out_raw` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 10 | Raw ADC sample |
| in_chan | input | 3 | Channel index of the sample |
| zs_mode | input | 1 | 1 = zero-suppressed (truncate), 0 = raw pass-through |
| gain_mask_we | input | 1 | Gain mask write strobe |
| gain_mask_wdata | input | 8 | New gain mask, one bit per channel, 1 = half gain |
| gain_mask_rd | output | 8 | Current gain mask |
| out_valid | output | 1 | Output qualifier, one cycle after in_valid |
| out_data | output | 10 | Processed sample (8-bit result zero-extended in zero-suppressed mode) |
| out_raw | output | 1 | 1 when out_data holds an untruncated raw sample |

## Verification
A mask write and a sample on the written channel can both arrive in the same clock. The bench presents a write that flips one channel's gain together with a sample on that channel. It expects the output to follow the old gain. The next sample on the same channel must follow the new gain, and the readback must show the new mask. The test is repeated in both directions (normal to half and half to normal) and with a saturating sample, so an early mask bypass shows up as a wrong slice or a missing clip.

// File: rtl/gain_trunc_pkg.sv
package gain_trunc_pkg;
  localparam int SAMPLE_W = 10;
  localparam int ZS_W     = 8;

  // Normal gain: keep the upper ZS_W bits of the sample.
  function automatic logic [ZS_W-1:0] slice_normal(input logic [SAMPLE_W-1:0] s);
    return s[SAMPLE_W-1 -: ZS_W];
  endfunction

  // Half gain: keep the middle bits; a set top bit clips to full scale.
  function automatic logic [ZS_W-1:0] slice_half(input logic [SAMPLE_W-1:0] s);
    logic [ZS_W-1:0] r;
    if (s[SAMPLE_W-1]) r = '1;
    else               r = s[SAMPLE_W-2 -: ZS_W];
    return r;
  endfunction

  typedef struct packed {
    logic                valid;
    logic                raw;
    logic [SAMPLE_W-1:0] data;
  } trunc_word_t;
endpackage

// File: rtl/gain_mask_reg.sv
module gain_mask_reg #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask <= '0;
    else if (we) mask <= wdata;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mask == $past(wdata)); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask)); // R8
endmodule

// File: rtl/sample_slicer.sv
module sample_slicer
  import gain_trunc_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [CH_W-1:0]     chan,
  input  logic                zs,
  input  logic [NUM_CH-1:0]   mask,
  output logic                half_sel,
  output logic                clip_hit,
  output logic [SAMPLE_W-1:0] result
);
  assign half_sel = zs & mask[chan];
  assign clip_hit = half_sel & sample[SAMPLE_W-1];

  always_comb begin
    if (!zs)           result = sample;
    else if (half_sel) result = {{(SAMPLE_W-ZS_W){1'b0}}, slice_half(sample)};
    else               result = {{(SAMPLE_W-ZS_W){1'b0}}, slice_normal(sample)};
  end
endmodule

// File: rtl/trunc_out_stage.sv
module trunc_out_stage
  import gain_trunc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  trunc_word_t d,
  output trunc_word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q.valid <= d.valid;
      if (d.valid) begin
        q.raw  <= d.raw;
        q.data <= d.data;
      end
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    q.valid == $past(d.valid)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !d.valid |=> ($stable(q.data) && $stable(q.raw))); // R10
endmodule

// File: rtl/gain_trunc_top.sv
module gain_trunc_top
  import gain_trunc_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [CH_W-1:0]     in_chan,
  input  logic                zs_mode,
  input  logic                gain_mask_we,
  input  logic [NUM_CH-1:0]   gain_mask_wdata,
  output logic [NUM_CH-1:0]   gain_mask_rd,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_raw
);
  logic [NUM_CH-1:0]   mask_q;
  logic                half_sel;
  logic                clip_hit;
  logic [SAMPLE_W-1:0] sliced;
  trunc_word_t         stage_d, stage_q;

  gain_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(gain_mask_we),
    .wdata(gain_mask_wdata), .mask(mask_q)
  );

  sample_slicer #(.NUM_CH(NUM_CH)) u_slice (
    .sample(in_sample), .chan(in_chan), .zs(zs_mode), .mask(mask_q),
    .half_sel(half_sel), .clip_hit(clip_hit), .result(sliced)
  );

  assign stage_d.valid = in_valid;
  assign stage_d.raw   = ~zs_mode;
  assign stage_d.data  = sliced;

  trunc_out_stage u_out (.clk(clk), .rst_n(rst_n), .d(stage_d), .q(stage_q));

  assign gain_mask_rd = mask_q;
  assign out_valid    = stage_q.valid;
  assign out_raw      = stage_q.raw;
  assign out_data     = stage_q.data;

  AST_ZS_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_raw) |-> out_data[SAMPLE_W-1:ZS_W] == '0); // R3
  AST_CLIP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clip_hit) |=> out_data == {{(SAMPLE_W-ZS_W){1'b0}}, {ZS_W{1'b1}}}); // R5
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zs_mode) |=> (out_raw && out_data == $past(in_sample))); // R6
  AST_HALF_ONLY_ZS: assert property (@(posedge clk) disable iff (!rst_n)
    !zs_mode |-> !half_sel); // R6
endmodule

// File: tb/gain_trunc_top_bench.sv
module gain_trunc_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_sample = '0;
  logic [2:0] in_chan = '0;
  logic       zs_mode = 1'b0;
  logic       gain_mask_we = 1'b0;
  logic [7:0] gain_mask_wdata = '0;
  logic [7:0] gain_mask_rd;
  logic       out_valid;
  logic [9:0] out_data;
  logic       out_raw;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gain_trunc_top u_gain_trunc_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .zs_mode(zs_mode), .gain_mask_we(gain_mask_we),
    .gain_mask_wdata(gain_mask_wdata), .gain_mask_rd(gain_mask_rd),
    .out_valid(out_valid), .out_data(out_data), .out_raw(out_raw)
  );

  function automatic int expect_zs(input int s, input bit half);
    if (!half) return s / 4;
    if (s >= 512) return 255;
    return s / 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge; outputs are sampled at the following negedge
  task automatic send(input int s, input int ch, input bit zs);
    in_valid = 1'b1; in_sample = s[9:0]; in_chan = ch[2:0]; zs_mode = zs;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic write_mask(input logic [7:0] m);
    gain_mask_we = 1'b1; gain_mask_wdata = m;
    @(negedge clk);
    gain_mask_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", out_valid, 0);
    check("R1 data", out_data, 0);
    check("R1 raw", out_raw, 0);
    check("R1 mask", gain_mask_rd, 0);
  endtask

  task automatic t_normal;
    int vals[4] = '{0, 3, 514, 1023};
    foreach (vals[i]) begin
      send(vals[i], i, 1'b1);
      check("R3 data", out_data, expect_zs(vals[i], 1'b0));
      check("R3 raw flag", out_raw, 0);
      check("R2 valid", out_valid, 1);
    end
  endtask

  task automatic t_half;
    write_mask(8'b0010_0000);
    check("R8 readback", gain_mask_rd, 8'h20);
    send(511, 5, 1'b1); check("R4 max unclipped", out_data, expect_zs(511, 1'b1));
    send(301, 5, 1'b1); check("R4 mid", out_data, expect_zs(301, 1'b1));
    send(512, 5, 1'b1); check("R5 clip low edge", out_data, 255);
    send(1023, 5, 1'b1); check("R5 clip top", out_data, 255);
    send(1023, 4, 1'b1); check("R7 neighbour normal", out_data, expect_zs(1023, 1'b0));
    send(301, 6, 1'b1); check("R7 neighbour normal", out_data, expect_zs(301, 1'b0));
  endtask

  task automatic t_raw;
    send(1023, 5, 1'b0);
    check("R6 raw data", out_data, 1023);
    check("R6 raw flag", out_raw, 1);
    send(517, 2, 1'b0);
    check("R6 raw data", out_data, 517);
  endtask

  task automatic t_idle;
    send(700, 1, 1'b1);
    in_sample = 10'h3FF; zs_mode = 1'b0;
    @(negedge clk);
    check("R2 idle valid", out_valid, 0);
    check("R10 hold data", out_data, expect_zs(700, 1'b0));
    check("R10 hold raw", out_raw, 0);
  endtask

  task automatic t_collide;
    // mask is 8'h20: channel 5 half, channel 3 normal
    gain_mask_we = 1'b1; gain_mask_wdata = 8'h08;
    send(1000, 3, 1'b1);
    gain_mask_we = 1'b0;
    check("R9 old gain used", out_data, expect_zs(1000, 1'b0));
    check("R8 new mask", gain_mask_rd, 8'h08);
    send(1000, 3, 1'b1);
    check("R9 new gain next", out_data, 255);
    gain_mask_we = 1'b1; gain_mask_wdata = 8'h00;
    send(600, 3, 1'b1);
    gain_mask_we = 1'b0;
    check("R9 old half used", out_data, 255);
    send(600, 3, 1'b1);
    check("R9 normal after", out_data, expect_zs(600, 1'b0));
    check("R8 cleared", gain_mask_rd, 0);
  endtask

  task automatic t_all_half;
    write_mask(8'hFF);
    for (int c = 0; c < 8; c++) begin
      send(c * 60 + 5, c, 1'b1);
      check("R7 all half", out_data, expect_zs(c * 60 + 5, 1'b1));
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #100000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_half();
    t_raw();
    t_idle();
    t_collide();
    t_all_half();
    summary();
  end
endmodule